// File: doc/BRIEF.md
# Delta-Sequence Read Prefetcher

This block sits between a processor's read/write request port and a memory request port. It watches the addresses of processor reads. It learns the differences between consecutive reads of each access stream and predicts the next address from them. A learned stream is not limited to one fixed stride. It can be a two-step cycle of unequal differences, such as reading two fields at fixed offsets inside records of a fixed size. When a stream has been confirmed often enough, the block sends a speculative fetch for the predicted line. The returned line is held in a small tag buffer. A later read of that line is then answered as a hit and never reaches memory.

Up to four streams are followed at once. A read joins the stream whose predicted next address it equals. If no stream predicts it, the read retrains a stream whose last address lies in the same 64-line region. If there is no such stream either, the read takes a free or least recently used slot. Misses and writes pass to the memory port combinationally, in the same cycle, so the block adds no delay to them. Addresses are line addresses.

Top module: `dpf_top`

## Requirements
- R1: After reset the buffer holds no line, no stream is trained, and with no request the memory port is idle (`mem_req_valid` = 0).
- R2: A read that misses the buffer appears on the memory port in the same cycle, with `mem_req_pf` = 0, `mem_req_write` = 0 and the same address. A write appears in the same cycle with `mem_req_write` = 1.
- R3: A read of a line held in the buffer raises `req_hit` in the same cycle and issues no demand request.
- R4: For a constant-stride stream, the fifth read confirms the prediction a second time. In the following cycle, if there is no demand, the block issues a prefetch (`mem_req_pf` = 1) for the fifth address plus the stride.
- R5: A stream that alternates between two unequal differences a, b is learned as well. The prefetch target is the current address plus the difference that follows the one just seen.
- R6: A read that lands in a tracked stream's region but off its prediction clears that stream's confidence. Neither that read nor the next read starts a prefetch.
- R7: Streams in different regions are trained and prefetched independently while their reads interleave.
- R8: A demand request always takes the memory port. A waiting prefetch is issued in the first cycle with no demand.
- R9: A stream has at most one prefetch outstanding. It issues no new prefetch until its line has been filled.
- R10: A filled line hits from the next cycle on, and also in the fill cycle itself when the read and the fill carry the same address.
- R11: A write invalidates a buffered line with the same address, and a later read of it misses. Other lines are unaffected.
- R12: With all four stream slots in use, a read that matches no stream and no region replaces the least recently used stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | AW | Request line address |
| req_hit | output | 1 | Read served from the prefetch buffer |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_pf | output | 1 | Memory request is a speculative prefetch |
| mem_req_addr | output | AW | Memory request line address |
| pf_fill_valid | input | 1 | Prefetched line returns |
| pf_fill_addr | input | AW | Address of the returning line |

## Verification
Hits and forwarded demand requests are combinational, so they are sampled one time step after inputs change in the same cycle. A read that arms a prefetch registers it at the next edge. The prefetch therefore shows on the memory port in the following cycle, provided no demand is driven then. Each scenario drives one idle cycle after each read and checks the prefetch there. A fill becomes visible in the buffer one edge later, except through the same-cycle bypass, which is checked by driving the read and the fill together.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  typedef enum logic [1:0] {
    CONF_NONE  = 2'd0,
    CONF_ONE   = 2'd1,
    CONF_ARMED = 2'd2,
    CONF_FULL  = 2'd3
  } conf_t;

  typedef enum logic [1:0] {
    UPD_MATCH = 2'd0,
    UPD_TRAIN = 2'd1,
    UPD_ALLOC = 2'd2
  } upd_e;

  function automatic conf_t conf_up(input conf_t c);
    conf_t r;
    case (c)
      CONF_NONE:  r = CONF_ONE;
      CONF_ONE:   r = CONF_ARMED;
      default:    r = CONF_FULL;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dpf_stream_tbl.sv
module dpf_stream_tbl
  import dpf_pkg::*;
#(
  parameter int AW = 16,
  parameter int NS = 4,
  parameter int RB = 6,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NS-1:0]    grant,
  input  logic             fill_valid,
  input  logic [AW-1:0]    fill_addr,
  output logic [NS-1:0]    pend,
  output logic [NS*AW-1:0] tgt_flat
);

  logic [NS-1:0] vld_q, vld_d, pend_q, pend_d, busy_q, busy_d;
  logic [AW-1:0] last_q [NS];
  logic [AW-1:0] last_d [NS];
  logic [AW-1:0] d0_q [NS];
  logic [AW-1:0] d0_d [NS];
  logic [AW-1:0] d1_q [NS];
  logic [AW-1:0] d1_d [NS];
  logic [AW-1:0] tgt_q [NS];
  logic [AW-1:0] tgt_d [NS];
  conf_t         conf_q [NS];
  conf_t         conf_d [NS];
  logic [IW-1:0] age_q [NS];
  logic [IW-1:0] age_d [NS];

  logic [NS-1:0] pred_hit, reg_hit;
  logic          pred_any, reg_any, free_any;
  logic [IW-1:0] psel, rsel, fsel, lsel, sel;
  upd_e          mode;
  logic [AW-1:0] delta;

  // stream selection: prediction first, then region, then free or LRU slot
  always_comb begin
    pred_any = 1'b0; reg_any = 1'b0; free_any = 1'b0;
    psel = '0; rsel = '0; fsel = '0; lsel = '0;
    pred_hit = '0; reg_hit = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      pred_hit[i] = vld_q[i] && ((last_q[i] + d0_q[i]) == rd_addr);
      reg_hit[i]  = vld_q[i] && (last_q[i][AW-1:RB] == rd_addr[AW-1:RB]);
      if (pred_hit[i]) begin pred_any = 1'b1; psel = IW'(i); end
      if (reg_hit[i])  begin reg_any  = 1'b1; rsel = IW'(i); end
      if (!vld_q[i])   begin free_any = 1'b1; fsel = IW'(i); end
      if (age_q[i] == IW'(NS - 1)) lsel = IW'(i);
    end
    if (pred_any) begin
      mode = UPD_MATCH; sel = psel;
    end else if (reg_any) begin
      mode = UPD_TRAIN; sel = rsel;
    end else begin
      mode = UPD_ALLOC; sel = free_any ? fsel : lsel;
    end
  end

  assign delta = rd_addr - last_q[sel];

  // next state
  always_comb begin
    vld_d = vld_q; pend_d = pend_q; busy_d = busy_q;
    last_d = last_q; d0_d = d0_q; d1_d = d1_q; tgt_d = tgt_q;
    conf_d = conf_q; age_d = age_q;
    for (int i = 0; i < NS; i++) begin
      if (fill_valid && busy_q[i] && (tgt_q[i] == fill_addr)) busy_d[i] = 1'b0;
      if (grant[i]) begin
        pend_d[i] = 1'b0;
        busy_d[i] = 1'b1;
      end
    end
    if (rd_valid) begin
      case (mode)
        UPD_MATCH: begin
          d0_d[sel]   = d1_q[sel];
          d1_d[sel]   = delta;
          conf_d[sel] = conf_up(conf_q[sel]);
          if ((conf_q[sel] != CONF_NONE) && !pend_q[sel] && !busy_q[sel]) begin
            pend_d[sel] = 1'b1;
            tgt_d[sel]  = rd_addr + d1_q[sel];
          end
        end
        UPD_TRAIN: begin
          d0_d[sel]   = d1_q[sel];
          d1_d[sel]   = delta;
          conf_d[sel] = CONF_NONE;
        end
        default: begin
          vld_d[sel]  = 1'b1;
          d0_d[sel]   = '0;
          d1_d[sel]   = '0;
          conf_d[sel] = CONF_NONE;
          pend_d[sel] = 1'b0;
          busy_d[sel] = 1'b0;
        end
      endcase
      last_d[sel] = rd_addr;
      for (int j = 0; j < NS; j++) begin
        if (IW'(j) == sel) age_d[j] = '0;
        else if (age_q[j] < age_q[sel]) age_d[j] = age_q[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      pend_q <= '0;
      busy_q <= '0;
      for (int i = 0; i < NS; i++) begin
        last_q[i] <= '0;
        d0_q[i]   <= '0;
        d1_q[i]   <= '0;
        tgt_q[i]  <= '0;
        conf_q[i] <= CONF_NONE;
        age_q[i]  <= IW'(i);
      end
    end else begin
      vld_q  <= vld_d;
      pend_q <= pend_d;
      busy_q <= busy_d;
      last_q <= last_d;
      d0_q   <= d0_d;
      d1_q   <= d1_d;
      tgt_q  <= tgt_d;
      conf_q <= conf_d;
      age_q  <= age_d;
    end
  end

  assign pend = pend_q;

  for (genvar g = 0; g < NS; g++) begin : g_strm
    assign tgt_flat[g*AW +: AW] = tgt_q[g];

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_q[g] && busy_q[g])); // R9

    AST_TRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && (mode == UPD_TRAIN) && (sel == IW'(g))) |=> (conf_q[g] == CONF_NONE)); // R6
  end

endmodule

// File: rtl/dpf_pf_buf.sv
module dpf_pf_buf #(
  parameter int AW = 16,
  parameter int NL = 8,
  localparam int PW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look_addr,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_addr,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  output logic          hit
);

  logic [NL-1:0] vld_q, vld_d, line_hit;
  logic [AW-1:0] tag_q [NL];
  logic [AW-1:0] tag_d [NL];
  logic [PW-1:0] ptr_q, ptr_d;

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic wr, kill;
    assign wr   = fill_valid && (ptr_q == PW'(g));
    assign kill = inv_valid && ((vld_q[g] && (tag_q[g] == inv_addr)) ||
                                (wr && (fill_addr == inv_addr)));
    assign vld_d[g]    = kill ? 1'b0 : (wr ? 1'b1 : vld_q[g]);
    assign tag_d[g]    = wr ? fill_addr : tag_q[g];
    assign line_hit[g] = vld_q[g] && (tag_q[g] == look_addr);
  end

  // fill bypass lets a read hit in the cycle its line arrives
  assign hit   = (|line_hit) || (fill_valid && (fill_addr == look_addr));
  assign ptr_d = !fill_valid ? ptr_q :
                 ((ptr_q == PW'(NL - 1)) ? '0 : ptr_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
      for (int i = 0; i < NL; i++) tag_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
      tag_q <= tag_d;
    end
  end

  function automatic logic holds(input logic [AW-1:0] a);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NL; i++) r = r | (vld_q[i] && (tag_q[i] == a));
    return r;
  endfunction

  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !holds($past(inv_addr))); // R11

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(inv_valid && (inv_addr == fill_addr))) |=> holds($past(fill_addr))); // R10

endmodule

// File: rtl/dpf_mem_arb.sv
module dpf_mem_arb #(
  parameter int AW = 16,
  parameter int NS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dem_valid,
  input  logic             dem_write,
  input  logic [AW-1:0]    dem_addr,
  input  logic [NS-1:0]    pend,
  input  logic [NS*AW-1:0] tgt_flat,
  output logic [NS-1:0]    grant,
  output logic             mem_req_valid,
  output logic             mem_req_write,
  output logic             mem_req_pf,
  output logic [AW-1:0]    mem_req_addr
);

  logic          pf_any;
  logic [AW-1:0] pf_addr;
  logic [NS-1:0] pf_pick;

  always_comb begin
    pf_any = 1'b0; pf_addr = '0; pf_pick = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pf_any  = 1'b1;
        pf_addr = tgt_flat[i*AW +: AW];
        pf_pick = NS'(1) << i;
      end
    end
  end

  always_comb begin
    grant = '0;
    mem_req_valid = 1'b0; mem_req_write = 1'b0; mem_req_pf = 1'b0; mem_req_addr = '0;
    if (dem_valid) begin
      mem_req_valid = 1'b1;
      mem_req_write = dem_write;
      mem_req_addr  = dem_addr;
    end else if (pf_any) begin
      grant         = pf_pick;
      mem_req_valid = 1'b1;
      mem_req_pf    = 1'b1;
      mem_req_addr  = pf_addr;
    end
  end

  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    dem_valid |-> (mem_req_valid && !mem_req_pf && (mem_req_addr == dem_addr))); // R8

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~pend) == '0)); // R9

endmodule

// File: rtl/dpf_top.sv
module dpf_top #(
  parameter int AW = 16,
  parameter int NS = 4,
  parameter int NL = 8,
  parameter int RB = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  output logic          req_hit,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic          mem_req_pf,
  output logic [AW-1:0] mem_req_addr,
  input  logic          pf_fill_valid,
  input  logic [AW-1:0] pf_fill_addr
);

  logic             rd_valid, wr_valid, buf_hit, dem_valid;
  logic [NS-1:0]    pend, grant;
  logic [NS*AW-1:0] tgt_flat;

  assign rd_valid  = req_valid && !req_write;
  assign wr_valid  = req_valid && req_write;
  assign req_hit   = rd_valid && buf_hit;
  assign dem_valid = wr_valid || (rd_valid && !buf_hit);

  dpf_pf_buf #(.AW(AW), .NL(NL)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .look_addr(req_addr),
    .fill_valid(pf_fill_valid), .fill_addr(pf_fill_addr),
    .inv_valid(wr_valid), .inv_addr(req_addr),
    .hit(buf_hit)
  );

  dpf_stream_tbl #(.AW(AW), .NS(NS), .RB(RB)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_addr(req_addr),
    .grant(grant),
    .fill_valid(pf_fill_valid), .fill_addr(pf_fill_addr),
    .pend(pend), .tgt_flat(tgt_flat)
  );

  dpf_mem_arb #(.AW(AW), .NS(NS)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .dem_valid(dem_valid), .dem_write(req_write), .dem_addr(req_addr),
    .pend(pend), .tgt_flat(tgt_flat),
    .grant(grant),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_pf(mem_req_pf), .mem_req_addr(mem_req_addr)
  );

  AST_HIT_NO_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |-> !(mem_req_valid && !mem_req_pf)); // R3

  AST_BYPASS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && pf_fill_valid && (pf_fill_addr == req_addr)) |-> req_hit); // R10

  AST_WRITE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (mem_req_valid && mem_req_write && !mem_req_pf)); // R2

endmodule

// File: tb/dpf_top_tb.sv
module dpf_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk, rst_n;
  logic          req_valid, req_write, req_hit;
  logic [AW-1:0] req_addr, mem_req_addr, pf_fill_addr;
  logic          mem_req_valid, mem_req_write, mem_req_pf, pf_fill_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dpf_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_hit(req_hit),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_pf(mem_req_pf), .mem_req_addr(mem_req_addr),
    .pf_fill_valid(pf_fill_valid), .pf_fill_addr(pf_fill_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = 0; req_write = 0; req_addr = '0;
    pf_fill_valid = 0; pf_fill_addr = '0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // read; outputs sampled in the same cycle
  task automatic rd(input logic [AW-1:0] a, input logic exp_hit, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; pf_fill_valid = 0;
    #1;
    check({tag, " hit"}, req_hit, exp_hit);
    if (!exp_hit) begin
      check({tag, " demand"}, {mem_req_valid, mem_req_pf, mem_req_write}, 3'b100);
      check({tag, " demand addr"}, mem_req_addr, a);
    end
  endtask

  // idle cycle: checks whether a prefetch is issued
  task automatic idle(input logic exp_pf, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    req_valid = 0; req_write = 0; pf_fill_valid = 0;
    #1;
    check({tag, " pf valid"}, mem_req_valid, exp_pf);
    if (exp_pf) begin
      check({tag, " pf flag"}, mem_req_pf, 1'b1);
      check({tag, " pf addr"}, mem_req_addr, a);
    end
  endtask

  task automatic fill(input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 0; pf_fill_valid = 1; pf_fill_addr = a;
  endtask

  task automatic t_reset_miss();
    do_reset();
    idle(1'b0, '0, "R1 idle after reset");
    rd(16'h0040, 1'b0, "R1 empty buffer");
    rd(16'h0123, 1'b0, "R2 read miss");
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'h0077;
    #1;
    check("R2 write forwarded", {mem_req_valid, mem_req_write, mem_req_pf}, 3'b110);
    check("R2 write addr", mem_req_addr, 16'h0077);
  endtask

  task automatic t_stride();
    do_reset();
    for (int k = 0; k < 4; k++) begin
      rd(16'h0100 + 16'(3 * k), 1'b0, "R4 stride train");
      idle(1'b0, '0, "R4 no early pf");
    end
    rd(16'h010C, 1'b0, "R4 fifth read");
    idle(1'b1, 16'h010F, "R4 stride pf");
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 16'h010F;
    pf_fill_valid = 1; pf_fill_addr = 16'h010F;
    #1;
    check("R10 fill bypass hit", req_hit, 1'b1);
    check("R3 hit no demand", mem_req_valid, 1'b0);
    fill(16'h0200);
    idle(1'b0, '0, "R10 after fill");
    rd(16'h0200, 1'b1, "R10 filled line hits");
  endtask

  task automatic t_alt();
    do_reset();
    rd(16'h1000, 1'b0, "R5 a0"); idle(1'b0, '0, "R5");
    rd(16'h1002, 1'b0, "R5 a1"); idle(1'b0, '0, "R5");
    rd(16'h100C, 1'b0, "R5 a2"); idle(1'b0, '0, "R5");
    rd(16'h100E, 1'b0, "R5 a3"); idle(1'b0, '0, "R5");
    rd(16'h1018, 1'b0, "R5 a4"); idle(1'b1, 16'h101A, "R5 first target");
    fill(16'h101A);
    idle(1'b0, '0, "R5 fill cycle");
    rd(16'h101A, 1'b1, "R5 prefetched hit");
    idle(1'b1, 16'h1024, "R5 second target");
  endtask

  task automatic t_break();
    do_reset();
    for (int k = 0; k < 4; k++) begin
      rd(16'h0300 + 16'(k), 1'b0, "R6 train");
      idle(1'b0, '0, "R6");
    end
    rd(16'h0304, 1'b0, "R6 trigger");
    idle(1'b1, 16'h0305, "R6 armed pf");
    fill(16'h0305);
    rd(16'h0320, 1'b0, "R6 off pattern");
    idle(1'b0, '0, "R6 no pf after break");
    rd(16'h0321, 1'b0, "R6 next read");
    idle(1'b0, '0, "R6 still unarmed");
  endtask

  task automatic t_multi();
    do_reset();
    for (int k = 0; k < 4; k++) begin
      rd(16'h0400 + 16'(k), 1'b0, "R7 A");
      idle(1'b0, '0, "R7 A");
      rd(16'h0800 + 16'(4 * k), 1'b0, "R7 B");
      idle(1'b0, '0, "R7 B");
    end
    rd(16'h0404, 1'b0, "R7 A5");
    idle(1'b1, 16'h0405, "R7 A pf");
    rd(16'h0810, 1'b0, "R7 B5");
    idle(1'b1, 16'h0814, "R7 B pf");
  endtask

  task automatic t_prio();
    do_reset();
    for (int k = 0; k < 4; k++) begin
      rd(16'h0500 + 16'(k), 1'b0, "R8 train");
      idle(1'b0, '0, "R8");
    end
    rd(16'h0504, 1'b0, "R8 trigger");
    rd(16'h0900, 1'b0, "R8 demand wins");
    idle(1'b1, 16'h0505, "R8 deferred pf");
  endtask

  task automatic t_one();
    do_reset();
    for (int k = 0; k < 4; k++) begin
      rd(16'h0600 + 16'(2 * k), 1'b0, "R9 train");
      idle(1'b0, '0, "R9");
    end
    rd(16'h0608, 1'b0, "R9 trigger");
    idle(1'b1, 16'h060A, "R9 first pf");
    rd(16'h060A, 1'b0, "R9 unfilled read");
    idle(1'b0, '0, "R9 no second pf");
    fill(16'h060A);
    idle(1'b0, '0, "R9 fill cycle");
    rd(16'h060C, 1'b0, "R9 after fill");
    idle(1'b1, 16'h060E, "R9 pf resumes");
  endtask

  task automatic t_inval();
    do_reset();
    fill(16'h0700);
    fill(16'h0701);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'h0700; pf_fill_valid = 0;
    #1;
    check("R11 write forwarded", {mem_req_valid, mem_req_write}, 2'b11);
    rd(16'h0700, 1'b0, "R11 invalidated line misses");
    rd(16'h0701, 1'b1, "R11 other line kept");
  endtask

  task automatic t_lru(input logic evict);
    do_reset();
    for (int k = 0; k < 4; k++) begin
      rd(16'h0A00 + 16'(k), 1'b0, "R12 A train");
      idle(1'b0, '0, "R12");
    end
    rd(16'h0B00, 1'b0, "R12 B"); idle(1'b0, '0, "R12");
    rd(16'h0C00, 1'b0, "R12 C"); idle(1'b0, '0, "R12");
    rd(16'h0D00, 1'b0, "R12 D"); idle(1'b0, '0, "R12");
    if (evict) begin
      rd(16'h0E00, 1'b0, "R12 E"); idle(1'b0, '0, "R12");
    end
    rd(16'h0A04, 1'b0, "R12 A resume");
    idle(!evict, 16'h0A05, evict ? "R12 LRU stream evicted" : "R12 stream kept");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_miss();
    t_stride();
    t_alt();
    t_break();
    t_multi();
    t_prio();
    t_one();
    t_inval();
    t_lru(1'b0);
    t_lru(1'b1);
    @(negedge clk);
    req_valid = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule